// File: doc/BRIEF.md
# I2C EEPROM Slave Address Front End

This block sits between a two-wire serial bus and the rest of a serial EEPROM. It oversamples the clock and data lines with the system clock, finds the bus framing conditions, and shifts in the first byte after each START. It then decides whether that byte addresses this device. A match needs the upper four bits to equal the fixed device-type code `1010`. The three bits that follow carry no device selection. Depending on the array size, each of them is either ignored or taken as a high-order memory address bit.

When the byte matches, the block pulls the data line low during the ninth bus clock to acknowledge. It also reports three things to the EEPROM core: a one-cycle match strobe, the read/write bit, and the extracted high address bits. Later bytes of the transaction, such as word addresses and data, are left to other logic. The front end stays quiet until the next START or STOP. The `DENSITY` parameter (0 to 3) gives the number of high-order address bits taken from the address byte.

Top module: `eeprom_addr_front`

## Requirements
- R1: After reset, sdaOe, addrMatch, rwBit and highAddr are all 0.
- R2: Bits clocked on the bus before any START (SDA falling while SCL is high) are ignored: no acknowledge and no addrMatch pulse.
- R3: After START, the block samples SDA on each SCL rising edge, MSB first, and the eighth bit completes the address byte.
- R4: A byte whose upper four bits differ from 1010 gets no acknowledge and no addrMatch pulse. rwBit and highAddr keep their previous values.
- R5: On a match, sdaOe rises after the SCL falling edge that ends the eighth bit, so SDA reads low while SCL is high in the ninth clock. sdaOe returns to 0 after the falling edge that ends the ninth clock.
- R6: Each matching address byte produces exactly one addrMatch pulse, one clock cycle wide, in the same cycle that sdaOe rises.
- R7: On a match, rwBit takes bit 0 of the byte (1 = read, 0 = write) and holds it until the next match.
- R8: Name the bits after the prefix m2, m1, m0, with m2 sent first (byte bits 3, 2, 1). They never affect matching. highAddr is 000 for DENSITY 0, {0,0,m0} for DENSITY 1, {0,m1,m0} for DENSITY 2 and {m2,m1,m0} for DENSITY 3. It is held until the next match.
- R9: A START seen part-way through the address byte discards the bits received so far and begins a fresh byte.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after it without a new START get no acknowledge.
- R11: After the acknowledge, further bytes in the same transaction get no acknowledge and no addrMatch pulse until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| addrMatch | output | 1 | One-cycle strobe on an accepted address byte |
| rwBit | output | 1 | Operation from the last accepted byte, 1 = read |
| highAddr | output | 3 | High-order array address bits; bits not used by DENSITY are 0 |

## Verification
The bus lines pass through two synchronizer stages and one edge-history register, and the results are registered once more. So sdaOe and addrMatch change on the third clock edge after SCL falls at the end of the eighth bit, and sdaOe clears on the third edge after the ninth falling edge. The bench holds every SCL phase for eight system clocks. It reads the acknowledge at the middle of the ninth high phase and checks its release one full low phase later, well clear of that three-edge latency. The addrMatch pulse is caught on the falling clock edge of the cycle it appears in and compared with the queued expectation. The held rwBit and highAddr values are checked once each transaction's ninth clock has ended. Three instances with DENSITY 0, 2 and 3 share one bus, so every address byte checks all three extraction variants.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_HOLD
  } eafState_t;

  typedef struct packed {
    logic clearBits;
    logic shiftBit;
    logic capture;
    logic ackClr;
  } eafStrobes_t;

  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
    logic byteFull;
    logic prefixOk;
  } eafStatus_t;

endpackage

// File: rtl/eaf_datapath.sv
module eaf_datapath
  import eaf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8,
  parameter int PREFIX_BITS = 4,
  parameter logic [PREFIX_BITS-1:0] PREFIX = 4'b1010,
  parameter int HI_WIDTH    = 3,
  parameter int DENSITY     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  eafStrobes_t         strobes,
  output eafStatus_t          status,
  output logic                sdaOe,
  output logic                addrMatch,
  output logic                rwBit,
  output logic [HI_WIDTH-1:0] highAddr
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;
  logic [HI_WIDTH-1:0]  extracted;

  // two-wire bus idles high, so synchronizers reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclD     <= sclS;
      sdaD     <= sdaS;
    end
  end

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  // framing: SDA moving while SCL stays high
  assign status.startSeen = sclS && sclD && sdaD && !sdaS;
  assign status.stopSeen  = sclS && sclD && !sdaD && sdaS;
  assign status.sclRise   = sclS && !sclD;
  assign status.sclFall   = !sclS && sclD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.clearBits) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign status.byteFull = (bitCnt == CNT_W'(BYTE_BITS));
  assign status.prefixOk = (shiftReg[BYTE_BITS-1 -: PREFIX_BITS] == PREFIX);

  // density picks how many middle bits become address bits
  for (genvar i = 0; i < HI_WIDTH; i++) begin : g_hi
    if (i < DENSITY) begin : g_used
      assign extracted[i] = shiftReg[i+1];
    end else begin : g_zero
      assign extracted[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      rwBit     <= 1'b0;
      highAddr  <= '0;
      sdaOe     <= 1'b0;
    end else begin
      addrMatch <= strobes.capture;
      if (strobes.capture) begin
        rwBit    <= shiftReg[0];
        highAddr <= extracted;
      end
      if (strobes.capture)     sdaOe <= 1'b1;
      else if (strobes.ackClr) sdaOe <= 1'b0;
    end
  end

endmodule

// File: rtl/eaf_control.sv
module eaf_control
  import eaf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  eafStatus_t  status,
  output eafStrobes_t strobes
);

  eafState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (status.startSeen) begin
      nextState         = ST_ADDR;
      strobes.clearBits = 1'b1;
      strobes.ackClr    = 1'b1;
    end else if (status.stopSeen) begin
      nextState         = ST_IDLE;
      strobes.clearBits = 1'b1;
      strobes.ackClr    = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (status.byteFull) begin
            if (status.sclFall) begin
              if (status.prefixOk) begin
                strobes.capture = 1'b1;
                nextState       = ST_ACK;
              end else begin
                nextState = ST_HOLD;
              end
            end
          end else if (status.sclRise) begin
            strobes.shiftBit = 1'b1;
          end
        end
        ST_ACK: begin
          if (status.sclFall) begin
            strobes.ackClr = 1'b1;
            nextState      = ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_addr_front.sv
module eeprom_addr_front
  import eaf_pkg::*;
#(
  parameter int DENSITY     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8,
  parameter int PREFIX_BITS = 4,
  parameter logic [PREFIX_BITS-1:0] PREFIX = 4'b1010,
  parameter int HI_WIDTH    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  output logic                addrMatch,
  output logic                rwBit,
  output logic [HI_WIDTH-1:0] highAddr
);

  eafStrobes_t strobes;
  eafStatus_t  status;

  eaf_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_BITS  (BYTE_BITS),
    .PREFIX_BITS(PREFIX_BITS),
    .PREFIX     (PREFIX),
    .HI_WIDTH   (HI_WIDTH),
    .DENSITY    (DENSITY)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobes  (strobes),
    .status   (status),
    .sdaOe    (sdaOe),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .highAddr (highAddr)
  );

  eaf_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobes(strobes)
  );

endmodule

// File: rtl/eeprom_addr_front_chk.sv
module eeprom_addr_front_chk #(
  parameter int DENSITY  = 3,
  parameter int HI_WIDTH = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                sdaOe,
  input logic                addrMatch,
  input logic                rwBit,
  input logic [HI_WIDTH-1:0] highAddr
);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |=> !addrMatch);

  a_r6_ack_with_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> addrMatch);

  a_r7_rw_held: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |-> $stable(rwBit));

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |-> $stable(highAddr));

  if (DENSITY < HI_WIDTH) begin : g_unused
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
      highAddr[HI_WIDTH-1:DENSITY] == '0);
  end

endmodule

bind eeprom_addr_front eeprom_addr_front_chk #(
  .DENSITY (DENSITY),
  .HI_WIDTH(HI_WIDTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .addrMatch(addrMatch),
  .rwBit    (rwBit),
  .highAddr (highAddr)
);

// File: tb/test_eeprom_addr_front.sv
`timescale 1ns/1ps
module test_eeprom_addr_front;

  localparam int HALF = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclMst = 1'b1;
  logic sdaMst = 1'b1;
  logic sdaLine;

  logic       oe2, oe0, oe3;
  logic       match2, match0, match3;
  logic       rw2, rw0, rw3;
  logic [2:0] hi2, hi0, hi3;

  int checkCount = 0;
  int failCount = 0;
  int pulseCount = 0;
  int expPulses = 0;
  logic [3:0] expQ[$];
  logic [7:0] heldByte = 8'h00;
  logic       heldValid = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = sdaMst & ~(oe2 | oe0 | oe3);

  eeprom_addr_front #(.DENSITY(2)) i_eeprom_addr_front (
    .clk(clk), .rstN(rstN), .sclIn(sclMst), .sdaIn(sdaLine),
    .sdaOe(oe2), .addrMatch(match2), .rwBit(rw2), .highAddr(hi2));

  eeprom_addr_front #(.DENSITY(0)) i_eeprom_addr_front_d0 (
    .clk(clk), .rstN(rstN), .sclIn(sclMst), .sdaIn(sdaLine),
    .sdaOe(oe0), .addrMatch(match0), .rwBit(rw0), .highAddr(hi0));

  eeprom_addr_front #(.DENSITY(3)) i_eeprom_addr_front_d3 (
    .clk(clk), .rstN(rstN), .sclIn(sclMst), .sdaIn(sdaLine),
    .sdaOe(oe3), .addrMatch(match3), .rwBit(rw3), .highAddr(hi3));

  function automatic logic [2:0] expHi(int d, logic [7:0] b);
    case (d)
      0:       return 3'b000;
      1:       return {2'b00, b[1]};
      2:       return {1'b0, b[2], b[1]};
      default: return b[3:1];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sampleEdge();
    @(negedge clk);
  endtask

  task automatic sendStart();
    sdaMst = 1'b1; waitCyc(HALF);
    sclMst = 1'b1; waitCyc(HALF);
    sdaMst = 1'b0; waitCyc(HALF);
    sclMst = 1'b0; waitCyc(HALF);
  endtask

  task automatic sendStop();
    sclMst = 1'b0; sdaMst = 1'b0; waitCyc(HALF);
    sclMst = 1'b1; waitCyc(HALF);
    sdaMst = 1'b1; waitCyc(HALF);
  endtask

  task automatic sendBit(logic b);
    sdaMst = b;    waitCyc(HALF);
    sclMst = 1'b1; waitCyc(HALF);
    sclMst = 1'b0; waitCyc(HALF);
  endtask

  task automatic ackSlot(logic expAck, string req);
    sdaMst = 1'b1; waitCyc(HALF);
    sampleEdge();
    check({req, " ack enable before ninth clock"}, 32'(oe2), 32'(expAck));
    sclMst = 1'b1; waitCyc(HALF / 2);
    sampleEdge();
    check({req, " SDA during ninth clock"}, 32'(sdaLine), 32'(!expAck));
    waitCyc(HALF / 2);
    sclMst = 1'b0; waitCyc(HALF);
    sampleEdge();
    check("R5 ack released after ninth clock", 32'(oe2 | oe0 | oe3), 32'(0));
  endtask

  task automatic checkHeld(string req);
    logic [7:0] b = heldValid ? heldByte : 8'h00;
    check({req, " rw D2"}, 32'(rw2), 32'(b[0]));
    check({req, " rw D0"}, 32'(rw0), 32'(b[0]));
    check({req, " rw D3"}, 32'(rw3), 32'(b[0]));
    check({req, " hi D2"}, 32'(hi2), 32'(expHi(2, b)));
    check({req, " hi D0"}, 32'(hi0), 32'(expHi(0, b)));
    check({req, " hi D3"}, 32'(hi3), 32'(expHi(3, b)));
  endtask

  // address byte after a START already on the bus
  task automatic addrByte(logic [7:0] b, logic expMatch, string req);
    if (expMatch) begin
      expQ.push_back({b[0], expHi(2, b)});
      expPulses++;
    end
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackSlot(expMatch, req);
    if (expMatch) begin
      heldByte  = b;
      heldValid = 1'b1;
    end
    checkHeld(expMatch ? "R7 R8 captured" : "R4 held");
  endtask

  task automatic frame(logic [7:0] b, logic expMatch, string req);
    sendStart();
    addrByte(b, expMatch, req);
  endtask

  task automatic rawByte(logic [7:0] b, string req);
    sclMst = 1'b0; waitCyc(HALF);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackSlot(1'b0, req);
  endtask

  // scoreboard monitor for the match strobe
  always @(negedge clk) begin
    if (rstN && match2) begin
      pulseCount++;
      if (expQ.size() == 0) begin
        checkCount++;
        failCount++;
        $display("FAIL R6 unexpected addrMatch: actual 1 expected 0 at %0t", $time);
      end else begin
        logic [3:0] e;
        e = expQ.pop_front();
        check("R7 rw at strobe", 32'(rw2), 32'(e[3]));
        check("R8 high address at strobe", 32'(hi2), 32'(e[2:0]));
        check("R6 ack rises with strobe", 32'(oe2), 32'(1));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    waitCyc(5);
    sampleEdge();
    check("R1 sdaOe reset", 32'(oe2), 32'(0));
    check("R1 addrMatch reset", 32'(match2), 32'(0));
    check("R1 rwBit reset", 32'(rw2), 32'(0));
    check("R1 highAddr reset", 32'(hi2), 32'(0));
    rstN = 1'b1;
    waitCyc(HALF);

    // R2: no START yet
    rawByte(8'hA0, "R2 before START");
    checkHeld("R2 held");

    // R3 R7 R8: matching reads and writes
    sclMst = 1'b1; waitCyc(HALF);
    frame(8'hA7, 1'b1, "R5 match A7");
    sendStop();
    frame(8'hAC, 1'b1, "R5 match AC");
    // R11: following byte in same transaction
    rawByte(8'hA1, "R11 data byte");
    checkHeld("R11 held");
    sendStop();

    // R4: prefix mismatches
    frame(8'h5E, 1'b0, "R4 mismatch 5E");
    sendStop();
    frame(8'hB3, 1'b0, "R4 mismatch B3");
    sendStop();
    frame(8'h21, 1'b0, "R4 mismatch 21");
    sendStop();

    // R9: repeated START part-way through a byte
    sendStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    frame(8'hAB, 1'b1, "R9 after restart");
    sendStop();

    // R10: bytes after STOP without START
    rawByte(8'hA3, "R10 after STOP");
    checkHeld("R10 held");
    sclMst = 1'b1; waitCyc(HALF);

    // R8: more middle-bit patterns, repeated START right after an ack
    frame(8'hAF, 1'b1, "R8 AF");
    frame(8'hA0, 1'b1, "R8 A0");
    frame(8'hA9, 1'b1, "R8 A9");
    frame(8'hA4, 1'b1, "R8 A4");
    sendStop();
    waitCyc(4 * HALF);

    check("R6 strobe count", 32'(pulseCount), 32'(expPulses));
    check("R6 no outstanding strobes", 32'(expQ.size()), 32'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule